// File: doc/BRIEF.md
# Eight-Channel Block-Transfer DMA Engine

This block moves bytes between a 24-bit main bus (A side) and a 256-entry peripheral register window (B side, at 0x2100 plus an index). Each channel owns a small byte-wide register set that the processor programs with a control byte, a 24-bit A address, a B index and a 16-bit byte count. A write of a channel mask to the launch register starts the selected channels. They are served one at a time, lowest index first, while the processor is held stalled through the `busy` output.

Every byte takes a read cycle on the source address followed by a write cycle on the destination address. The B-side address follows a per-mode offset pattern. The A-side address can count up, count down or stay put. After every byte the engine stores the new A address and the remaining count back into the channel registers, so a register read shows the live state of the transfer.

Top module: `gdma_engine`

## Requirements
- R1: After reset `busy`, `bus_rd` and `bus_wr` are low, and the launch register and every channel register read 0x00.
- R2: Channel c registers sit at 0x4300 | (c << 4) | k, with k = 0 control, 1 B index, 2 A address bits 7:0, 3 A bits 15:8, 4 A bank (bits 23:16), 5 count bits 7:0, 6 count bits 15:8. Offsets 7 to 15 read 0x00 and ignore writes. `cpu_rdata` follows `cpu_addr` combinationally, and a write takes effect at the clock edge on which `cpu_we` is high.
- R3: A write to 0x420B while idle latches the channel mask in bit i = channel i. With a nonzero mask, `busy` and `bus_rd` are high in the next cycle. The launch register reads back the mask while the engine runs and reads 0x00 once the last channel ends. A zero mask starts nothing.
- R4: Selected channels run one after another in ascending channel order, each to completion.
- R5: Each byte uses two cycles. In the first, `bus_rd` is high with `bus_addr` = source. In the second, `bus_wr` is high with `bus_addr` = destination and `bus_wdata` equal to `bus_rdata` sampled in the first. The two strobes are never high together.
- R6: With control bit 7 = 0 the source is the A address {bank, bits 15:8, bits 7:0} and the destination is 0x0021xx, where xx = (B index + offset) mod 256. With bit 7 = 1 the two are swapped.
- R7: Control bits 2:0 select the B offset for successive bytes, repeating per unit: mode 0 {0}, mode 1 {0,1}, mode 2 {0,0}, mode 3 {0,0,1,1}, mode 4 {0,1,2,3}, mode 5 {0,1,0,1}. Modes 6 and 7 behave as modes 2 and 3. The pattern starts at its first entry when each channel starts.
- R8: After each byte, control bits 4:3 step the A address: 00 adds 1, 10 subtracts 1, 01 and 11 leave it unchanged. The step wraps within bits 15:0 and never changes the bank.
- R9: Each byte lowers the count by one and the channel ends after the byte that takes it to zero. A starting count of 0 moves 65536 bytes.
- R10: After every byte the channel's A address and count registers hold the updated values. The B index and control byte are unchanged. After completion the count reads 0 and the A address reads its final stepped value.
- R11: `busy` stays high for exactly two cycles per byte moved across all selected channels. The read cycle of each next byte, including the first byte of the next channel, directly follows the previous write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_we | input | 1 | Processor register write strobe (ignored while busy) |
| cpu_addr | input | 16 | Processor register address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rdata | output | 8 | Register read data for `cpu_addr` |
| busy | output | 1 | Engine active; processor must stall |
| bus_addr | output | 24 | Source or destination address of the current cycle |
| bus_rd | output | 1 | Read strobe for the source byte |
| bus_wr | output | 1 | Write strobe for the destination byte |
| bus_wdata | output | 8 | Byte being written |
| bus_rdata | input | 8 | Byte returned by the source |

## Verification
The hardest cases are the ones where several counters hit their limits at once. These include a channel that ends partway through its offset pattern while the next queued channel must restart the pattern, an A address that crosses the 16-bit boundary with the bank held, and a B index that wraps past 0xFF. The stimulus sweeps every mode, step setting and direction, with start addresses placed next to the wrap points and byte counts that are not multiples of the unit length. Each byte is checked against a bench model of the offset pattern. Separate runs cover a multi-channel mask and a zero count, which moves the full 65536 bytes.

// File: rtl/gdma_pkg.sv
// Shared types and helpers of the block-transfer DMA engine.
// Assumes 24-bit A addresses and 16-bit byte counts.
package gdma_pkg;
    localparam int AW   = 24;
    localparam int CNTW = 16;

    // Register offsets inside one channel's 16-byte window.
    localparam logic [3:0] OFF_PRM = 4'd0;
    localparam logic [3:0] OFF_BIX = 4'd1;
    localparam logic [3:0] OFF_ALO = 4'd2;
    localparam logic [3:0] OFF_AHI = 4'd3;
    localparam logic [3:0] OFF_ABK = 4'd4;
    localparam logic [3:0] OFF_CLO = 4'd5;
    localparam logic [3:0] OFF_CHI = 4'd6;

    typedef struct packed {
        logic [7:0]      prm;
        logic [7:0]      bidx;
        logic [AW-1:0]   aadr;
        logic [CNTW-1:0] cnt;
    } gdma_chan_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } gdma_state_e;

    // Folds the two alias modes onto their base modes.
    function automatic logic [2:0] eff_mode(input logic [2:0] m);
        return (m[2] & m[1]) ? {1'b0, m[1:0]} : m;
    endfunction

    // B offset for position u inside the unit of mode m.
    function automatic logic [1:0] unit_off(input logic [2:0] m, input logic [1:0] u);
        case (m)
            3'd1, 3'd5: return {1'b0, u[0]};
            3'd3:       return {1'b0, u[1]};
            3'd4:       return u;
            default:    return 2'd0;
        endcase
    endfunction

    // Last position of the unit of mode m.
    function automatic logic [1:0] unit_last(input logic [2:0] m);
        case (m)
            3'd0:       return 2'd0;
            3'd1, 3'd2: return 2'd1;
            default:    return 2'd3;
        endcase
    endfunction
endpackage

// File: rtl/gdma_regfile.sv
// Per-channel register storage. The processor writes bytes and the engine
// writes back the A address and the count, with the engine taking priority.
// Assumes the top gates processor writes with the window decode and busy.
module gdma_regfile
    import gdma_pkg::*;
#(
    parameter int NCH = 8,
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cpu_we,
    input  logic [CW-1:0]   cpu_ch,
    input  logic [3:0]      cpu_off,
    input  logic [7:0]      cpu_wdata,
    output logic [7:0]      cpu_rdata,
    input  logic            wb_en,
    input  logic [CW-1:0]   wb_ch,
    input  logic [AW-1:0]   wb_aadr,
    input  logic [CNTW-1:0] wb_cnt,
    input  logic [CW-1:0]   eng_ch,
    output gdma_chan_t      eng_cfg
);
    gdma_chan_t chan_view [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        gdma_chan_t q;

        // Holds one channel; engine write-back wins over processor writes.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wb_en && wb_ch == CW'(g)) begin
                q.aadr <= wb_aadr;
                q.cnt  <= wb_cnt;
            end else if (cpu_we && cpu_ch == CW'(g)) begin
                case (cpu_off)
                    OFF_PRM: q.prm          <= cpu_wdata;
                    OFF_BIX: q.bidx         <= cpu_wdata;
                    OFF_ALO: q.aadr[7:0]    <= cpu_wdata;
                    OFF_AHI: q.aadr[15:8]   <= cpu_wdata;
                    OFF_ABK: q.aadr[23:16]  <= cpu_wdata;
                    OFF_CLO: q.cnt[7:0]     <= cpu_wdata;
                    OFF_CHI: q.cnt[15:8]    <= cpu_wdata;
                    default: ;
                endcase
            end
        end

        assign chan_view[g] = q;
    end

    assign eng_cfg = chan_view[eng_ch];

    // Selects the byte the processor is reading.
    always_comb begin
        gdma_chan_t r;
        r = chan_view[cpu_ch];
        case (cpu_off)
            OFF_PRM: cpu_rdata = r.prm;
            OFF_BIX: cpu_rdata = r.bidx;
            OFF_ALO: cpu_rdata = r.aadr[7:0];
            OFF_AHI: cpu_rdata = r.aadr[15:8];
            OFF_ABK: cpu_rdata = r.aadr[23:16];
            OFF_CLO: cpu_rdata = r.cnt[7:0];
            OFF_CHI: cpu_rdata = r.cnt[15:8];
            default: cpu_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/gdma_pick.sv
// Chooses the lowest-numbered pending channel.
// Assumes pend is a registered mask; the clock only serves the check below.
module gdma_pick #(
    parameter int NCH = 8,
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] pend,
    output logic [CW-1:0]  grant_ch,
    output logic           any
);
    // Priority scan, highest index first so the lowest set bit wins.
    always_comb begin
        grant_ch = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (pend[i]) grant_ch = CW'(i);
        end
    end

    assign any = |pend;

    // R4: the granted channel is pending and no lower channel is pending.
    p_lowest_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> (pend[grant_ch] &&
                 ((pend & ((NCH'(1) << grant_ch) - NCH'(1))) == '0)));
endmodule

// File: rtl/gdma_lane.sv
// Address generator for one byte of the active channel: the source and
// destination addresses, the stepped A address and the next unit position.
// Assumes cfg and unit are stable for the whole byte.
module gdma_lane
    import gdma_pkg::*;
#(
    parameter logic [7:0] B_PAGE = 8'h21
) (
    input  gdma_chan_t     cfg,
    input  logic [1:0]     unit,
    output logic [AW-1:0]  src_addr,
    output logic [AW-1:0]  dst_addr,
    output logic [AW-1:0]  a_next,
    output logic [1:0]     unit_next
);
    logic [2:0]    mode;
    logic [1:0]    off;
    logic [AW-1:0] b_full;

    // Builds the B address from the offset pattern and picks the direction.
    always_comb begin
        mode   = eff_mode(cfg.prm[2:0]);
        off    = unit_off(mode, unit);
        b_full = {8'h00, B_PAGE, cfg.bidx + {6'b0, off}};
        if (cfg.prm[7]) begin
            src_addr = b_full;
            dst_addr = cfg.aadr;
        end else begin
            src_addr = cfg.aadr;
            dst_addr = b_full;
        end
    end

    // Steps the A address inside its 16-bit page and advances the unit.
    always_comb begin
        a_next = cfg.aadr;
        case (cfg.prm[4:3])
            2'b00:   a_next[15:0] = cfg.aadr[15:0] + 16'd1;
            2'b10:   a_next[15:0] = cfg.aadr[15:0] - 16'd1;
            default: ;
        endcase
        unit_next = (unit == unit_last(mode)) ? 2'd0 : unit + 2'd1;
    end
endmodule

// File: rtl/gdma_engine.sv
// Multi-channel block-transfer DMA engine. A write of a mask to the launch
// register queues channels, served lowest first, two cycles per byte
// (read, then write), with live write-back of A address and count.
// Assumes the processor honours busy; register writes while busy are dropped.
module gdma_engine
    import gdma_pkg::*;
#(
    parameter int          NCH        = 8,
    parameter logic [15:0] START_ADDR = 16'h420B,
    parameter logic [7:0]  CHAN_PAGE  = 8'h43,
    parameter logic [7:0]  B_PAGE     = 8'h21,
    localparam int         CW         = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cpu_we,
    input  logic [15:0] cpu_addr,
    input  logic [7:0]  cpu_wdata,
    output logic [7:0]  cpu_rdata,
    output logic        busy,
    output logic [23:0] bus_addr,
    output logic        bus_rd,
    output logic        bus_wr,
    output logic [7:0]  bus_wdata,
    input  logic [7:0]  bus_rdata
);
    gdma_state_e    state;
    logic [NCH-1:0] pend;
    logic [NCH-1:0] start_q;
    logic [1:0]     unit_q;
    logic [7:0]     data_q;

    logic [3:0]     chan_fld;
    logic           win_hit;
    logic           start_hit;
    logic [7:0]     rf_rdata;
    logic [CW-1:0]  cur_ch;
    logic           any_pend;
    gdma_chan_t     cfg;
    logic [AW-1:0]  src_addr;
    logic [AW-1:0]  dst_addr;
    logic [AW-1:0]  a_next;
    logic [1:0]     unit_next;
    logic           last_byte;
    logic [NCH-1:0] pend_clr;

    assign chan_fld  = cpu_addr[7:4];
    assign win_hit   = (cpu_addr[15:8] == CHAN_PAGE) && (chan_fld < 4'(NCH));
    assign start_hit = (cpu_addr == START_ADDR);
    assign busy      = (state != ST_IDLE);
    assign last_byte = (cfg.cnt == 16'd1);
    assign pend_clr  = pend & ~(NCH'(1) << cur_ch);

    gdma_regfile #(.NCH(NCH)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_we    (cpu_we && win_hit && !busy),
        .cpu_ch    (chan_fld[CW-1:0]),
        .cpu_off   (cpu_addr[3:0]),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (rf_rdata),
        .wb_en     (state == ST_WR),
        .wb_ch     (cur_ch),
        .wb_aadr   (a_next),
        .wb_cnt    (cfg.cnt - 16'd1),
        .eng_ch    (cur_ch),
        .eng_cfg   (cfg)
    );

    gdma_pick #(.NCH(NCH)) pick_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend     (pend),
        .grant_ch (cur_ch),
        .any      (any_pend)
    );

    gdma_lane #(.B_PAGE(B_PAGE)) lane_i (
        .cfg       (cfg),
        .unit      (unit_q),
        .src_addr  (src_addr),
        .dst_addr  (dst_addr),
        .a_next    (a_next),
        .unit_next (unit_next)
    );

    // Launch, byte sequencing and channel hand-over.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            pend    <= '0;
            start_q <= '0;
            unit_q  <= 2'd0;
            data_q  <= 8'h00;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (cpu_we && start_hit) begin
                        start_q <= cpu_wdata[NCH-1:0];
                        pend    <= cpu_wdata[NCH-1:0];
                        unit_q  <= 2'd0;
                        if (cpu_wdata[NCH-1:0] != '0) state <= ST_RD;
                    end
                end
                ST_RD: begin
                    data_q <= bus_rdata;
                    state  <= ST_WR;
                end
                ST_WR: begin
                    if (last_byte) begin
                        pend   <= pend_clr;
                        unit_q <= 2'd0;
                        if (pend_clr == '0) begin
                            state   <= ST_IDLE;
                            start_q <= '0;
                        end else begin
                            state <= ST_RD;
                        end
                    end else begin
                        unit_q <= unit_next;
                        state  <= ST_RD;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Drives the bus of the current cycle.
    always_comb begin
        bus_rd    = (state == ST_RD);
        bus_wr    = (state == ST_WR);
        bus_wdata = data_q;
        case (state)
            ST_RD:   bus_addr = src_addr;
            ST_WR:   bus_addr = dst_addr;
            default: bus_addr = '0;
        endcase
    end

    // Register read mux: launch register or channel window.
    always_comb begin
        if (start_hit)    cpu_rdata = 8'(start_q);
        else if (win_hit) cpu_rdata = rf_rdata;
        else              cpu_rdata = 8'h00;
    end

    // R5: one strobe at a time.
    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    // R5: a read is followed by a write of the byte that was read.
    p_read_then_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> (bus_wr && bus_wdata == $past(bus_rdata)));

    // R3: a nonzero launch while idle makes the engine busy and reading.
    p_launch_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cpu_we && start_hit && cpu_wdata[NCH-1:0] != '0)
            |=> (busy && bus_rd));

    // R3: the launch register is clear once the engine goes idle.
    p_launch_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (start_q == '0));

    // R11: after a write the engine either reads the next byte or is idle.
    p_gapless_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> (busy == bus_rd));
endmodule

// File: tb/gdma_engine_tb_top.sv
// Self-checking bench: sweeps modes, steps and directions, multi-channel
// ordering, zero mask and the full 65536-byte count.
module gdma_engine_tb_top;
    localparam logic [15:0] START = 16'h420B;
    localparam int MAXREC = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_we = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_wdata = 8'h00;
    logic [7:0]  cpu_rdata;
    logic        busy;
    logic [23:0] bus_addr;
    logic        bus_rd;
    logic        bus_wr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    function automatic logic [7:0] mem(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
    endfunction

    assign bus_rdata = mem(bus_addr);

    gdma_engine dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .busy      (busy),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    // Bench-side channel configuration.
    logic [7:0]  c_prm [8];
    logic [7:0]  c_bix [8];
    logic [23:0] c_a   [8];
    logic [15:0] c_n   [8];
    logic [23:0] fin_a [8];

    // Expected and observed byte records.
    logic [23:0] exp_src [MAXREC];
    logic [23:0] exp_dst [MAXREC];
    logic [23:0] got_src [MAXREC];
    logic [23:0] got_dst [MAXREC];
    logic [7:0]  got_dat [MAXREC];
    int exp_n = 0;
    int mon_n = 0;
    int busy_cyc = 0;
    logic [23:0] last_rd = '0;

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 195000) begin
            n_bad++;
            $display("FAIL watchdog got=%0d cycles exp=<195000", cyc);
            summary();
        end
    end

    // Records every byte moved, away from the active edge.
    always @(negedge clk) begin
        if (busy) busy_cyc++;
        if (bus_rd) last_rd = bus_addr;
        if (bus_wr) begin
            if (mon_n < MAXREC) begin
                got_src[mon_n] = last_rd;
                got_dst[mon_n] = bus_addr;
                got_dat[mon_n] = bus_wdata;
            end
            mon_n++;
        end
    end

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] expv);
        n_chk++;
        if (got !== expv) begin
            n_bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, expv);
        end
    endtask

    task automatic cpu_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr  = a;
        cpu_wdata = d;
        cpu_we    = 1'b1;
        @(negedge clk);
        cpu_we    = 1'b0;
    endtask

    task automatic cpu_rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_addr = a;
        #1;
        d = cpu_rdata;
    endtask

    function automatic logic [15:0] creg(input int c, input int k);
        return 16'h4300 | 16'(c << 4) | 16'(k);
    endfunction

    task automatic prog(input int c);
        cpu_wr(creg(c, 0), c_prm[c]);
        cpu_wr(creg(c, 1), c_bix[c]);
        cpu_wr(creg(c, 2), c_a[c][7:0]);
        cpu_wr(creg(c, 3), c_a[c][15:8]);
        cpu_wr(creg(c, 4), c_a[c][23:16]);
        cpu_wr(creg(c, 5), c_n[c][7:0]);
        cpu_wr(creg(c, 6), c_n[c][15:8]);
    endtask

    // Unit length and offsets of each mode, from R7.
    function automatic int plen(input int m);
        case (m)
            0:       return 1;
            1, 2, 6: return 2;
            default: return 4;
        endcase
    endfunction

    function automatic int poff(input int m, input int u);
        case (m)
            1, 5:    return u % 2;
            3, 7:    return u / 2;
            4:       return u;
            default: return 0;
        endcase
    endfunction

    // Builds the expected byte list for a mask from R4, R6, R7, R8, R9.
    task automatic expect_run(input logic [7:0] mask);
        exp_n = 0;
        for (int c = 0; c < 8; c++) begin
            if (mask[c]) begin
                int n;
                int m;
                int l;
                logic [23:0] a;
                logic [23:0] b;
                n = (c_n[c] == 16'd0) ? 65536 : int'(c_n[c]);
                a = c_a[c];
                m = int'(c_prm[c][2:0]);
                l = plen(m);
                for (int k = 0; k < n; k++) begin
                    b = {8'h00, 8'h21, 8'(int'(c_bix[c]) + poff(m, k % l))};
                    if (exp_n < MAXREC) begin
                        exp_src[exp_n] = c_prm[c][7] ? b : a;
                        exp_dst[exp_n] = c_prm[c][7] ? a : b;
                    end
                    exp_n++;
                    if (c_prm[c][4:3] == 2'b00) a[15:0] = a[15:0] + 16'd1;
                    else if (c_prm[c][4:3] == 2'b10) a[15:0] = a[15:0] - 16'd1;
                end
                fin_a[c] = a;
            end
        end
    endtask

    // Launches, waits for idle and checks sequence, timing and write-back.
    task automatic run(input logic [7:0] mask, input string tag, input bit peek);
        logic [7:0] v;
        logic [7:0] lo;
        logic [7:0] hi;
        logic [7:0] bk;
        expect_run(mask);
        mon_n = 0;
        busy_cyc = 0;
        cpu_wr(START, mask);
        if (peek) begin
            cpu_rd(START, v);
            chk({"R3 launch reg while running ", tag}, 64'(v), 64'(mask));
        end
        while (busy) @(negedge clk);
        chk({"R11 busy cycles ", tag}, 64'(busy_cyc), 64'(2 * exp_n));
        chk({"R9 bytes moved ", tag}, 64'(mon_n), 64'(exp_n));
        for (int i = 0; i < exp_n && i < MAXREC && i < mon_n; i++) begin
            chk({"R4 R5 R6 R7 R8 byte ", tag},
                {got_src[i], got_dst[i], got_dat[i]},
                {exp_src[i], exp_dst[i], mem(exp_src[i])});
        end
        cpu_rd(START, v);
        chk({"R3 launch reg cleared ", tag}, 64'(v), 64'h0);
        for (int c = 0; c < 8; c++) begin
            if (mask[c]) begin
                cpu_rd(creg(c, 2), lo);
                cpu_rd(creg(c, 3), hi);
                cpu_rd(creg(c, 4), bk);
                chk({"R10 R8 final A ", tag}, 64'({bk, hi, lo}), 64'(fin_a[c]));
                cpu_rd(creg(c, 5), lo);
                cpu_rd(creg(c, 6), hi);
                chk({"R10 final count ", tag}, 64'({hi, lo}), 64'h0);
                cpu_rd(creg(c, 1), lo);
                cpu_rd(creg(c, 0), hi);
                chk({"R10 B index and control kept ", tag}, 64'({hi, lo}),
                    64'({c_prm[c], c_bix[c]}));
            end
        end
    endtask

    initial begin
        logic [7:0] v;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state.
        @(negedge clk);
        chk("R1 busy", 64'(busy), 64'h0);
        chk("R1 strobes", 64'({bus_rd, bus_wr}), 64'h0);
        cpu_rd(START, v);
        chk("R1 launch reg", 64'(v), 64'h0);
        for (int c = 0; c < 8; c++) begin
            for (int k = 0; k < 7; k++) begin
                cpu_rd(creg(c, k), v);
                chk("R1 channel reg", 64'(v), 64'h0);
            end
        end

        // R2: register write and read-back, unused offsets.
        for (int c = 0; c < 8; c++) begin
            for (int k = 0; k < 16; k++) cpu_wr(creg(c, k), 8'((c * 16 + k) ^ 8'hA5));
        end
        for (int c = 0; c < 8; c++) begin
            for (int k = 0; k < 16; k++) begin
                cpu_rd(creg(c, k), v);
                chk("R2 register read-back", 64'(v),
                    (k < 7) ? 64'(8'((c * 16 + k) ^ 8'hA5)) : 64'h0);
            end
        end

        // R3: zero mask starts nothing.
        cpu_wr(START, 8'h00);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R3 zero mask idle", 64'({busy, bus_rd, bus_wr}), 64'h0);
        end

        // Sweep of mode, step and direction on single channels.
        for (int k = 0; k < 64; k++) begin
            int c;
            int st;
            c = k % 8;
            st = (k / 8) % 4;
            c_prm[c] = {1'(k / 32), 2'b00, 2'(st), 3'(k % 8)};
            c_bix[c] = 8'(8'hFC + (k % 5));
            c_a[c][23:16] = 8'(k * 7);
            c_a[c][15:0] = (st == 0) ? 16'hFFFD : ((st == 2) ? 16'h0002 : 16'h1234);
            c_n[c] = 16'(3 + (k % 6));
            prog(c);
            run(8'(1 << c), $sformatf("sweep %0d", k), 1'b0);
        end

        // R4: several channels, lowest first, pattern restart per channel.
        for (int c = 0; c < 8; c++) begin
            c_prm[c] = {1'(c % 2), 2'b00, 2'(c % 4), 3'(7 - c)};
            c_bix[c] = 8'(8'h10 * c + 8'h0F);
            c_a[c] = {8'(c + 1), 16'(16'h8000 + c * 3)};
            c_n[c] = 16'(c + 2);
            prog(c);
        end
        run(8'hA5, "mask A5", 1'b1);
        for (int c = 0; c < 8; c++) prog(c);
        run(8'hFF, "mask FF", 1'b1);
        prog(7);
        run(8'h80, "mask 80", 1'b0);

        // R9: count 0 moves 65536 bytes.
        c_prm[3] = 8'h04;
        c_bix[3] = 8'h18;
        c_a[3] = 24'h124000;
        c_n[3] = 16'h0000;
        prog(3);
        run(8'h08, "count zero", 1'b0);

        summary();
    end
endmodule